// File: doc/BRIEF.md
# Endpoint Prime and Flush Command Controller

This block holds the per-endpoint "buffer ready" status of a device-side USB endpoint engine. The engine has `NUM_EP` endpoints, and each endpoint has a transmit direction and a receive direction. Software primes or flushes endpoint directions by writing ones to two command registers on a simple register bus. It polls a read-only status register for the ready bits.

Pending primes go one at a time to the DMA side over a valid/ready request channel. A ready bit is set only after the DMA side accepts the request. Flushes are deferred: a flush waits until any packet in flight on that direction has finished. It then discards the primed buffer and clears its own command bit.

The DMA side also reports consumed buffers and retired descriptors. A retired descriptor causes a brief drop of ready while hardware re-primes. A USB bus-reset input clears all state.

Internally each endpoint direction is a channel. Transmit endpoint k is channel k. Receive endpoint k is channel `NUM_EP`+k. The request channel follows valid/ready rules. `prime_valid` and `prime_chan` are held stable until a cycle in which `prime_ready` is high. That cycle completes the handshake. The DMA side may hold `prime_ready` low for as long as it needs. The only exception is bus reset, which withdraws a pending request without a handshake.

Top module: `epc_top`

## Requirements
- R1: Register layout. The prime command register is at offset 0x00, the flush command register at 0x04 and the status register at 0x08. In each of them, transmit endpoint k is bit 16+k and receive endpoint k is bit k. All other bits read as zero. A read strobe returns its data on `rd_data` in the cycle after the strobe.
- R2: Writing a one to a prime bit makes that channel pending. Writing zero has no effect. The ready bit of a channel is set in the cycle after the DMA side accepts its request, never directly by the write.
- R3: Pending primes are offered one per request, lowest channel code first. All transmit endpoints therefore come before all receive endpoints, and lower endpoint numbers come first. `prime_chan` carries the channel code.
- R4: While `prime_valid` is high and `prime_ready` is low, `prime_valid` and `prime_chan` stay unchanged in the next cycle. Bus reset is the only exception.
- R5: Writing a one to a flush bit makes that flush pending. Writing zero has no effect. While `xfer_busy` is high for that channel, the flush stays pending and the ready bit is kept.
- R6: Once the channel is not busy, a pending flush clears the channel's ready bit and any pending prime of that channel. It then clears its own flush bit.
- R7: If a prime handshake for a channel happens in the same cycle as that channel's flush completion, the flush wins and the ready bit stays clear.
- R8: A `buf_consumed` pulse clears the channel's ready bit.
- R9: A `desc_retire` pulse drops the channel's ready bit for exactly one cycle. The bit is then set again.
- R10: A `bus_reset` cycle clears every ready bit, every pending prime, every pending flush and the outstanding request by the next clock.
- R11: Writes to the status register are ignored.
- R12: After `rst_n` is released, all three registers read zero and `prime_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset, synchronous clear |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Registered read data |
| prime_valid | output | 1 | Prime request offered to DMA side |
| prime_chan | output | CW | Channel code of the offered request |
| prime_ready | input | 1 | DMA side accepts the request |
| xfer_busy | input | 2*NUM_EP | Packet in progress, one bit per channel |
| buf_consumed | input | 2*NUM_EP | Buffer consumed pulse per channel |
| desc_retire | input | 2*NUM_EP | Descriptor retired and re-primed pulse per channel |

## Verification
The following are checked by the assertions on every cycle:
- the request hold rule while `prime_ready` is low;
- that a ready bit only rises after an accepted request or a re-prime;
- that a busy channel keeps its flush pending;
- that a completed flush, a retire pulse or a flush that collides with a handshake leaves ready clear in the next cycle;
- that bus reset empties everything.

Only the bench scenarios can show the following:
- the service order across a multi-bit prime write;
- the exact bit positions in the three registers;
- the restoration of ready one cycle after a retire;
- that writes of zero or writes to the status register change nothing visible.

// File: rtl/epc_pkg.sv
package epc_pkg;

  parameter int unsigned EPC_DEF_NUM_EP = 3;
  parameter int unsigned EPC_DEF_TX_LSB = 16;
  parameter int unsigned EPC_DEF_RX_LSB = 0;

  typedef enum logic [1:0] {
    SEL_PRIME  = 2'd0,
    SEL_FLUSH  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } epc_sel_e;

  // Register bit position of channel c (transmit channels first).
  function automatic int unsigned chan_bit(int unsigned c, int unsigned n_ep,
                                           int unsigned tx_lsb, int unsigned rx_lsb);
    return (c < n_ep) ? (tx_lsb + c) : (rx_lsb + c - n_ep);
  endfunction

endpackage

// File: rtl/epc_regs.sv
module epc_regs
  import epc_pkg::*;
#(
  parameter int unsigned NUM_EP    = EPC_DEF_NUM_EP,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TX_LSB    = EPC_DEF_TX_LSB,
  parameter int unsigned RX_LSB    = EPC_DEF_RX_LSB,
  parameter int unsigned OFF_PRIME = 0,
  parameter int unsigned OFF_FLUSH = 4,
  parameter int unsigned OFF_STAT  = 8,
  localparam int unsigned NCH      = 2 * NUM_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NCH-1:0]    prime_take,
  input  logic [NCH-1:0]    flush_done,
  input  logic [NCH-1:0]    status,
  output logic [NCH-1:0]    prime_pend,
  output logic [NCH-1:0]    flush_pend
);

  epc_sel_e          wr_sel, rd_sel;
  logic [NCH-1:0]    wr_bits;
  logic [DATA_W-1:0] prime_word, flush_word, stat_word, rd_next;

  function automatic epc_sel_e decode(logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFF_PRIME))      return SEL_PRIME;
    else if (a == ADDR_W'(OFF_FLUSH)) return SEL_FLUSH;
    else if (a == ADDR_W'(OFF_STAT))  return SEL_STAT_fix();
    else                              return SEL_NONE;
  endfunction

  function automatic epc_sel_e SEL_STAT_fix();
    return SEL_STATUS;
  endfunction

  assign wr_sel = wr_en ? decode(wr_addr) : SEL_NONE;
  assign rd_sel = decode(rd_addr);

  // Map register bits to channels and back.
  always_comb begin
    wr_bits    = '0;
    prime_word = '0;
    flush_word = '0;
    stat_word  = '0;
    for (int unsigned c = 0; c < NCH; c++) begin
      wr_bits[c]                                    = wr_data[chan_bit(c, NUM_EP, TX_LSB, RX_LSB)];
      prime_word[chan_bit(c, NUM_EP, TX_LSB, RX_LSB)] = prime_pend[c];
      flush_word[chan_bit(c, NUM_EP, TX_LSB, RX_LSB)] = flush_pend[c];
      stat_word[chan_bit(c, NUM_EP, TX_LSB, RX_LSB)]  = status[c];
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_PRIME:  rd_next = prime_word;
      SEL_FLUSH:  rd_next = flush_word;
      SEL_STATUS: rd_next = stat_word;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_pend <= '0;
      flush_pend <= '0;
      rd_data    <= '0;
    end else begin
      if (rd_en) rd_data <= rd_next;
      if (bus_reset) begin
        prime_pend <= '0;
        flush_pend <= '0;
      end else begin
        prime_pend <= (prime_pend & ~prime_take & ~flush_done)
                    | ((wr_sel == SEL_PRIME) ? wr_bits : '0);
        flush_pend <= (flush_pend & ~flush_done)
                    | ((wr_sel == SEL_FLUSH) ? wr_bits : '0);
      end
    end
  end

  // Flush completion must also remove a pending prime of that channel.
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      a_r6_prime_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_done[g] && !(wr_sel == SEL_PRIME && wr_bits[g])) |=> !prime_pend[g])
        else $error("R6 pending prime survived flush on channel %0d", g);
    end
  endgenerate

endmodule

// File: rtl/epc_prime_arb.sv
module epc_prime_arb #(
  parameter int unsigned NUM_EP = 3,
  localparam int unsigned NCH   = 2 * NUM_EP,
  localparam int unsigned CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_reset,
  input  logic [NCH-1:0] cand,
  input  logic           prime_ready,
  output logic           prime_valid,
  output logic [CW-1:0]  prime_chan,
  output logic [NCH-1:0] take,
  output logic [NCH-1:0] hs_oh
);

  logic [CW-1:0]  pick;
  logic [NCH-1:0] pick_oh;
  logic           can_load, any;

  // Lowest set candidate wins.
  always_comb begin
    pick    = '0;
    pick_oh = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick    = CW'(i);
        pick_oh = NCH'(1) << i;
      end
    end
  end

  assign any      = |cand;
  assign can_load = (!prime_valid || prime_ready) && !bus_reset;
  assign take     = (can_load && any) ? pick_oh : '0;
  assign hs_oh    = (prime_valid && prime_ready) ? (NCH'(1) << prime_chan) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_valid <= 1'b0;
      prime_chan  <= '0;
    end else if (bus_reset) begin
      prime_valid <= 1'b0;
    end else if (can_load) begin
      prime_valid <= any;
      if (any) prime_chan <= pick;
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_valid && !prime_ready && !bus_reset) |=> (prime_valid && $stable(prime_chan)))
    else $error("R4 request changed while stalled");

  a_r3_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take))
    else $error("R3 more than one prime served in a cycle");

endmodule

// File: rtl/epc_ready_track.sv
module epc_ready_track #(
  parameter int unsigned NUM_EP = 3,
  localparam int unsigned NCH   = 2 * NUM_EP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_reset,
  input  logic [NCH-1:0] xfer_busy,
  input  logic [NCH-1:0] buf_consumed,
  input  logic [NCH-1:0] desc_retire,
  input  logic [NCH-1:0] hs_oh,
  input  logic [NCH-1:0] flush_pend,
  output logic [NCH-1:0] flush_done,
  output logic [NCH-1:0] ready
);

  logic [NCH-1:0] reprime;

  assign flush_done = flush_pend & ~xfer_busy;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ready[c]   <= 1'b0;
          reprime[c] <= 1'b0;
        end else if (bus_reset || flush_done[c]) begin
          ready[c]   <= 1'b0;
          reprime[c] <= 1'b0;
        end else if (buf_consumed[c]) begin
          ready[c]   <= 1'b0;
          reprime[c] <= 1'b0;
        end else if (desc_retire[c]) begin
          ready[c]   <= 1'b0;
          reprime[c] <= 1'b1;
        end else if (reprime[c] || hs_oh[c]) begin
          ready[c]   <= 1'b1;
          reprime[c] <= 1'b0;
        end
      end

      a_r2_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready[c]) |-> $past(hs_oh[c] || reprime[c]))
        else $error("R2 ready rose without acceptance on channel %0d", c);

      a_r5_flush_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pend[c] && xfer_busy[c] && ready[c] && !bus_reset
         && !buf_consumed[c] && !desc_retire[c]) |=> ready[c])
        else $error("R5 ready lost while flush waited on channel %0d", c);

      a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pend[c] && !xfer_busy[c]) |=> !ready[c])
        else $error("R6 flush completion left ready set on channel %0d", c);

      a_r7_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_oh[c] && flush_done[c]) |=> !ready[c])
        else $error("R7 prime beat flush on channel %0d", c);

      a_r9_retire_drop: assert property (@(posedge clk) disable iff (!rst_n)
        desc_retire[c] |=> !ready[c])
        else $error("R9 retire did not drop ready on channel %0d", c);
    end
  endgenerate

endmodule

// File: rtl/epc_top.sv
module epc_top
  import epc_pkg::*;
#(
  parameter int unsigned NUM_EP = EPC_DEF_NUM_EP,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TX_LSB = EPC_DEF_TX_LSB,
  parameter int unsigned RX_LSB = EPC_DEF_RX_LSB,
  localparam int unsigned NCH   = 2 * NUM_EP,
  localparam int unsigned CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              prime_valid,
  output logic [CW-1:0]     prime_chan,
  input  logic              prime_ready,
  input  logic [NCH-1:0]    xfer_busy,
  input  logic [NCH-1:0]    buf_consumed,
  input  logic [NCH-1:0]    desc_retire
);

  logic [NCH-1:0] prime_pend, flush_pend, flush_done, ready, take, hs_oh;

  epc_regs #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TX_LSB(TX_LSB), .RX_LSB(RX_LSB)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .prime_take (take),
    .flush_done (flush_done),
    .status     (ready),
    .prime_pend (prime_pend),
    .flush_pend (flush_pend)
  );

  epc_prime_arb #(.NUM_EP(NUM_EP)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset   (bus_reset),
    .cand        (prime_pend & ~flush_pend),
    .prime_ready (prime_ready),
    .prime_valid (prime_valid),
    .prime_chan  (prime_chan),
    .take        (take),
    .hs_oh       (hs_oh)
  );

  epc_ready_track #(.NUM_EP(NUM_EP)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_reset    (bus_reset),
    .xfer_busy    (xfer_busy),
    .buf_consumed (buf_consumed),
    .desc_retire  (desc_retire),
    .hs_oh        (hs_oh),
    .flush_pend   (flush_pend),
    .flush_done   (flush_done),
    .ready        (ready)
  );

  a_r10_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (ready == '0 && prime_pend == '0 && flush_pend == '0 && !prime_valid))
    else $error("R10 state survived bus reset");

endmodule

// File: tb/test_epc_top.sv
module test_epc_top;

  localparam int NUM_EP = 3;
  localparam int NCH    = 2 * NUM_EP;
  localparam int CW     = $clog2(NCH);
  localparam logic [7:0] A_PRIME = 8'h00;
  localparam logic [7:0] A_FLUSH = 8'h04;
  localparam logic [7:0] A_STAT  = 8'h08;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_reset = 1'b0;
  logic           wr_en = 1'b0;
  logic [7:0]     wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic           rd_en = 1'b0;
  logic [7:0]     rd_addr = '0;
  logic [31:0]    rd_data;
  logic           prime_valid;
  logic [CW-1:0]  prime_chan;
  logic           prime_ready = 1'b0;
  logic [NCH-1:0] xfer_busy = '0;
  logic [NCH-1:0] buf_consumed = '0;
  logic [NCH-1:0] desc_retire = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  epc_top i_epc_top (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .prime_valid(prime_valid), .prime_chan(prime_chan), .prime_ready(prime_ready),
    .xfer_busy(xfer_busy), .buf_consumed(buf_consumed), .desc_retire(desc_retire)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R12 prime_valid", 32'(prime_valid), 0);
    reg_rd(A_PRIME, v); check("R12 prime reg", v, 0);
    reg_rd(A_FLUSH, v); check("R12 flush reg", v, 0);
    reg_rd(A_STAT, v);  check("R12 status reg", v, 0);
  endtask

  task automatic t_zero_write();
    logic [31:0] v;
    reg_wr(A_PRIME, 32'h0);
    repeat (3) @(negedge clk);
    check("R2 zero write no request", 32'(prime_valid), 0);
    reg_rd(A_STAT, v); check("R2 zero write no ready", v, 0);
  endtask

  task automatic t_single_prime();
    logic [31:0] v;
    prime_ready = 1'b0;
    reg_wr(A_PRIME, 32'h0002_0000);           // transmit endpoint 1
    check("R2 not ready in write cycle", 32'(prime_valid), 0);
    @(posedge clk); @(negedge clk);
    check("R3 valid for tx1", 32'(prime_valid), 1);
    check("R3 chan code tx1", 32'(prime_chan), 1);
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R4 valid held", 32'(prime_valid), 1);
      check("R4 chan held", 32'(prime_chan), 1);
    end
    reg_rd(A_STAT, v); check("R2 not ready before accept", v, 0);
    @(negedge clk); prime_ready = 1'b1;
    @(posedge clk); @(negedge clk); prime_ready = 1'b0;
    check("R4 valid drops after accept", 32'(prime_valid), 0);
    reg_rd(A_STAT, v); check("R2 ready after accept", v, 32'h0002_0000);
    reg_rd(A_PRIME, v); check("R1 prime reg empty", v, 0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    int seen[$];
    @(negedge clk); prime_ready = 1'b1;
    reg_wr(A_PRIME, 32'h0005_0001);           // rx0, tx0, tx2
    repeat (6) begin
      @(posedge clk); @(negedge clk);
      if (prime_valid) seen.push_back(int'(prime_chan));
    end
    prime_ready = 1'b0;
    check("R3 served count", 32'(seen.size()), 3);
    if (seen.size() == 3) begin
      check("R3 first tx0", 32'(seen[0]), 0);
      check("R3 second tx2", 32'(seen[1]), 2);
      check("R3 third rx0", 32'(seen[2]), 3);
    end
    reg_rd(A_STAT, v); check("R1 status layout", v, 32'h0007_0001);
  endtask

  task automatic t_flush_wait();
    logic [31:0] v;
    xfer_busy[3] = 1'b1;
    reg_wr(A_FLUSH, 32'h0000_0001);           // receive endpoint 0
    repeat (4) @(negedge clk);
    reg_rd(A_FLUSH, v); check("R5 flush held while busy", v, 32'h1);
    reg_rd(A_STAT, v);  check("R5 ready kept while busy", v, 32'h0007_0001);
    @(negedge clk); xfer_busy[3] = 1'b0;
    repeat (2) @(negedge clk);
    reg_rd(A_FLUSH, v); check("R6 flush bit self-cleared", v, 0);
    reg_rd(A_STAT, v);  check("R6 ready cleared by flush", v, 32'h0007_0000);
  endtask

  task automatic t_consume();
    logic [31:0] v;
    @(negedge clk); buf_consumed[0] = 1'b1;
    @(negedge clk); buf_consumed[0] = 1'b0;
    reg_rd(A_STAT, v); check("R8 consume clears tx0", v, 32'h0006_0000);
  endtask

  task automatic t_retire();
    @(negedge clk);
    desc_retire[2] = 1'b1; rd_en = 1'b1; rd_addr = A_STAT;
    @(posedge clk); @(negedge clk);
    desc_retire[2] = 1'b0;
    check("R9 ready before retire", 32'(rd_data[18]), 1);
    @(posedge clk); @(negedge clk);
    check("R9 ready dropped", 32'(rd_data[18]), 0);
    @(posedge clk); @(negedge clk);
    check("R9 ready restored", 32'(rd_data[18]), 1);
    rd_en = 1'b0;
  endtask

  task automatic t_flush_wins();
    logic [31:0] v;
    reg_wr(A_PRIME, 32'h0002_0000);           // tx1 again
    @(posedge clk); @(negedge clk);
    check("R7 request offered", 32'(prime_valid), 1);
    reg_wr(A_FLUSH, 32'h0002_0000);
    prime_ready = 1'b1;                       // accept coincides with flush completion
    @(posedge clk); @(negedge clk);
    prime_ready = 1'b0;
    reg_rd(A_STAT, v);  check("R7 flush wins", v, 32'h0004_0000);
    reg_rd(A_FLUSH, v); check("R7 flush bit cleared", v, 0);
  endtask

  task automatic t_status_ro();
    logic [31:0] v;
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    reg_rd(A_STAT, v); check("R11 status write ignored", v, 32'h0004_0000);
    check("R11 no request from status write", 32'(prime_valid), 0);
  endtask

  task automatic t_bus_reset();
    logic [31:0] v;
    reg_wr(A_PRIME, 32'h0003_0000);           // tx0, tx1 with no acceptance
    xfer_busy[4] = 1'b1;
    reg_wr(A_FLUSH, 32'h0000_0002);           // rx1 held by busy
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    check("R10 request withdrawn", 32'(prime_valid), 0);
    reg_rd(A_STAT, v);  check("R10 status cleared", v, 0);
    reg_rd(A_PRIME, v); check("R10 primes cleared", v, 0);
    reg_rd(A_FLUSH, v); check("R10 flushes cleared", v, 0);
    xfer_busy[4] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_zero_write();
    t_single_prime();
    t_priority();
    t_flush_wait();
    t_consume();
    t_retire();
    t_flush_wins();
    t_status_ro();
    t_bus_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule